// File: doc/BRIEF.md
# Measurement Mux Conversion Sequencer

This block decides which analog input a single shared converter samples in each conversion slot. Four logical channels compete for the converter: the current-sense difference, the current amplifier offset (a calibration sample), the supply voltage, and an auxiliary input. For every slot the block raises a one-cycle start pulse together with a physical mux code and a channel tag. It then waits for the converter's done strobe and files the 12-bit result into the holding register of the channel that was sampled.

A 7-bit control register sets the schedule. A rate field chooses how often offset calibrations are interleaved: every other slot, every 8th slot, every 16th slot, or only on a restart. A mix field chooses the order of the remaining slots. A source field picks which physical pin supplies the voltage sample. Any write to the register restarts the schedule. The conversion already running is allowed to finish, but its result is discarded. The next two slots are then a fresh offset calibration and a fresh supply-voltage sample, whatever mode was written, and only after that does the selected pattern begin.

Top module: `conv_sequencer`

## Requirements
- R1: After reset is released, the first start pulse selects the offset calibration: `conv_mux` = 1 and `conv_chan` = 0.
- R2: After a control write, the conversion in progress runs to completion. The next slot is then an offset calibration (mux 1), and the slot after it is a supply-voltage sample.
- R3: With rate code 2'b00, every second slot is a calibration. Under mix 3'b000, the other slots rotate voltage, current, auxiliary, with current following the forced voltage slot. Current uses mux 0 and auxiliary uses mux 4.
- R4: With rate code 2'b01, one calibration occurs per 16 slots (CAL_SLOW): one calibration, then fifteen other slots.
- R5: With rate code 2'b10, one calibration occurs per 8 slots (CAL_MID).
- R6: With rate code 2'b11, calibrations occur only at the restart that follows reset or a control write.
- R7: Mix 3'b110 converts current on every non-calibration slot. Mix 3'b001 alternates voltage and current. Every other mix code behaves like the round robin of 3'b000.
- R8: A voltage slot drives mux 2 (supply pin) for source 2'b00, mux 3 (positive sense input) for 2'b01 or 2'b11, and mux 4 (auxiliary pin) for 2'b10. Channel tags are 0 offset, 1 current, 2 voltage, 3 auxiliary.
- R9: One cycle after an accepted done strobe, `res_valid` pulses for exactly one cycle. At the same time `res_chan` carries the slot's tag, and that channel's holding register holds the result.
- R10: A conversion with a control write during its start or wait cycles, or in the cycle its done strobe arrives, produces no `res_valid`, and every holding register keeps its value.
- R11: `conv_start` lasts one cycle. The next start follows the cycle after an accepted done. A done strobe in a start cycle is ignored.
- R12: The control word layout is bits [1:0] rate, [3:2] source, [6:4] mix. The reset value is rate 2'b00, source 2'b01 and mix 3'b000, and all holding registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control word |
| conv_start | output | 1 | One-cycle conversion start |
| conv_mux | output | 3 | Physical input select for the current slot |
| conv_chan | output | 2 | Logical channel tag of the current slot |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | DATA_W | Converter result |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 2 | Channel tag of the routed result |
| offset_q | output | DATA_W | Latest offset calibration result |
| current_q | output | DATA_W | Latest current result |
| volt_q | output | DATA_W | Latest supply-voltage result |
| aux_q | output | DATA_W | Latest auxiliary result |

## Verification
A corrupted schedule counter, rotation pointer or forced-voltage flag shows on `conv_mux` at the very next start pulse. The bench therefore records every mux code after a write and compares the whole slot pattern against the expected one. A stale discard flag is caught at the next done strobe: either a `res_valid` pulse is missing, or a result appears for a conversion that should have been dropped. A corrupted routing tag is visible one cycle after done, because the wrong holding register changes.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_CUR  = 2'd1,
      CH_VOLT = 2'd2,
      CH_AUX  = 2'd3
   } chan_e;

   localparam logic [2:0] MUX_DIFF   = 3'd0;
   localparam logic [2:0] MUX_ZERO   = 3'd1;
   localparam logic [2:0] MUX_SUPPLY = 3'd2;
   localparam logic [2:0] MUX_SENSEP = 3'd3;
   localparam logic [2:0] MUX_AUXPIN = 3'd4;

   localparam logic [1:0] RATE_EVERY2  = 2'b00;
   localparam logic [1:0] RATE_SLOW    = 2'b01;
   localparam logic [1:0] RATE_MID     = 2'b10;
   localparam logic [1:0] RATE_RESTART = 2'b11;

   localparam logic [2:0] MIX_ROUND   = 3'b000;
   localparam logic [2:0] MIX_VI      = 3'b001;
   localparam logic [2:0] MIX_CURRENT = 3'b110;

   localparam logic [1:0] SRC_SUPPLY = 2'b00;
   localparam logic [1:0] SRC_SENSEP = 2'b01;
   localparam logic [1:0] SRC_AUXPIN = 2'b10;

   typedef struct packed {
      logic [2:0] mix;
      logic [1:0] src;
      logic [1:0] rate;
   } ctrl_t;

   localparam int    CTRL_W     = $bits(ctrl_t);
   localparam ctrl_t CTRL_RESET = '{mix: MIX_ROUND, src: SRC_SENSEP, rate: RATE_EVERY2};

endpackage

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
   import conv_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output ctrl_t             ctrl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl <= CTRL_RESET;
      else if (wr_en) ctrl <= ctrl_t'(wr_data);
   end

endmodule

// File: rtl/conv_seq_pick.sv
module conv_seq_pick
   import conv_seq_pkg::*;
#(
   parameter int CAL_MID  = 8,
   parameter int CAL_SLOW = 16,
   parameter int CNT_W    = 4
)
(
   input  logic [1:0]       rate,
   input  logic [2:0]       mix,
   input  logic             restart,
   input  logic [CNT_W-1:0] cnt,
   input  logic             force_v,
   input  chan_e            last_chan,
   output chan_e            nxt_chan,
   output logic [CNT_W-1:0] nxt_cnt,
   output logic             nxt_force,
   output chan_e            nxt_last
);

   localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(CAL_MID - 1);
   localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(CAL_SLOW - 1);
   localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};

   logic [CNT_W-1:0] lim;
   logic             periodic;
   logic [CNT_W-1:0] cnt_inc;
   chan_e            rr_chan;

   always_comb begin
      periodic = 1'b1;
      unique case (rate)
         RATE_EVERY2: lim = CNT_W'(1);
         RATE_SLOW:   lim = LIM_SLOW;
         RATE_MID:    lim = LIM_MID;
         default: begin
            lim      = CNT_TOP;
            periodic = 1'b0;
         end
      endcase
   end

   assign cnt_inc = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;

   always_comb begin
      if (mix == MIX_CURRENT) begin
         rr_chan = CH_CUR;
      end else if (mix == MIX_VI) begin
         rr_chan = (last_chan == CH_VOLT) ? CH_CUR : CH_VOLT;
      end else begin
         unique case (last_chan)
            CH_VOLT: rr_chan = CH_CUR;
            CH_CUR:  rr_chan = CH_AUX;
            default: rr_chan = CH_VOLT;
         endcase
      end
   end

   always_comb begin
      nxt_chan  = rr_chan;
      nxt_cnt   = cnt_inc;
      nxt_force = 1'b0;
      nxt_last  = rr_chan;
      if (restart) begin
         nxt_chan  = CH_OFF;
         nxt_cnt   = '0;
         nxt_force = 1'b1;
         nxt_last  = CH_VOLT;
      end else if (force_v) begin
         nxt_chan  = CH_VOLT;
         nxt_last  = CH_VOLT;
      end else if (periodic && (cnt >= lim)) begin
         nxt_chan  = CH_OFF;
         nxt_cnt   = '0;
         nxt_last  = last_chan;
      end
   end

endmodule

// File: rtl/conv_seq_slot.sv
module conv_seq_slot
   import conv_seq_pkg::*;
#(
   parameter int CNT_W = 4
)
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             conv_done,
   input  logic [1:0]       rate,
   input  logic [2:0]       mix,
   input  chan_e            nxt_chan,
   input  logic [CNT_W-1:0] nxt_cnt,
   input  logic             nxt_force,
   input  chan_e            nxt_last,
   output chan_e            slot_chan,
   output logic [CNT_W-1:0] cnt,
   output logic             force_v,
   output chan_e            last_chan,
   output logic             conv_start,
   output logic             restart,
   output logic             accept,
   output logic             drop
);

   typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT} st_e;

   st_e  st;
   logic restart_pend;
   logic discard;
   logic done_taken;

   assign conv_start = (st == S_START);
   assign restart    = restart_pend | ctrl_we;
   assign done_taken = (st == S_WAIT) & conv_done;
   assign accept     = done_taken & ~discard & ~ctrl_we;
   assign drop       = done_taken & (discard | ctrl_we);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         slot_chan    <= CH_OFF;
         cnt          <= '0;
         force_v      <= 1'b1;
         last_chan    <= CH_VOLT;
         restart_pend <= 1'b0;
         discard      <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: begin
               st           <= S_START;
               restart_pend <= 1'b0;
               discard      <= 1'b0;
            end
            S_START: begin
               st <= S_WAIT;
               if (ctrl_we) begin
                  restart_pend <= 1'b1;
                  discard      <= 1'b1;
               end
            end
            default: begin
               if (conv_done) begin
                  st           <= S_START;
                  slot_chan    <= nxt_chan;
                  cnt          <= nxt_cnt;
                  force_v      <= nxt_force;
                  last_chan    <= nxt_last;
                  restart_pend <= 1'b0;
                  discard      <= 1'b0;
               end else if (ctrl_we) begin
                  restart_pend <= 1'b1;
                  discard      <= 1'b1;
               end
            end
         endcase
      end
   end

   p_first_cal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |=> (conv_start && slot_chan == CH_OFF));

   p_restart_cal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_taken && restart) |=> (conv_start && slot_chan == CH_OFF));

   p_forced_volt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_taken && !restart && force_v) |=> (slot_chan == CH_VOLT));

   p_cont_current_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_taken && !restart && !force_v && mix == MIX_CURRENT && rate == RATE_RESTART)
      |=> (slot_chan == CH_CUR));

   p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_next_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_taken |=> conv_start);

endmodule

// File: rtl/conv_seq_route.sv
module conv_seq_route
   import conv_seq_pkg::*;
#(
   parameter int DATA_W = 12
)
(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        accept,
   input  logic                        drop,
   input  chan_e                       chan,
   input  logic [DATA_W-1:0]           data,
   output logic [3:0][DATA_W-1:0]      hold_q,
   output logic                        res_valid,
   output chan_e                       res_chan
);

   for (genvar i = 0; i < 4; i++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              hold_q[i] <= '0;
         else if (accept && chan == chan_e'(i))   hold_q[i] <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_chan  <= CH_OFF;
      end else begin
         res_valid <= accept;
         if (accept) res_chan <= chan;
      end
   end

   p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_valid_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (res_valid && res_chan == $past(chan)));

   p_drop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> (!res_valid && $stable(hold_q)));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import conv_seq_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CAL_MID  = 8,
   parameter int CAL_SLOW = 16
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic              conv_start,
   output logic [2:0]        conv_mux,
   output logic [1:0]        conv_chan,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic              res_valid,
   output logic [1:0]        res_chan,
   output logic [DATA_W-1:0] offset_q,
   output logic [DATA_W-1:0] current_q,
   output logic [DATA_W-1:0] volt_q,
   output logic [DATA_W-1:0] aux_q
);

   localparam int CNT_W = $clog2(CAL_SLOW);

   if (DATA_W < 2)          begin : g_bad_width $error("DATA_W must be at least 2"); end
   if (CAL_MID < 3)         begin : g_bad_mid   $error("CAL_MID must be at least 3"); end
   if (CAL_SLOW <= CAL_MID) begin : g_bad_slow  $error("CAL_SLOW must exceed CAL_MID"); end

   ctrl_t                   ctrl;
   chan_e                   slot_chan, last_chan, nxt_chan, nxt_last, tag;
   logic [CNT_W-1:0]        cnt, nxt_cnt;
   logic                    force_v, nxt_force, restart, accept, drop;
   logic [3:0][DATA_W-1:0]  hold_q;

   conv_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctrl_we),
      .wr_data (ctrl_wdata),
      .ctrl    (ctrl)
   );

   conv_seq_pick #(.CAL_MID(CAL_MID), .CAL_SLOW(CAL_SLOW), .CNT_W(CNT_W)) u_pick (
      .rate      (ctrl.rate),
      .mix       (ctrl.mix),
      .restart   (restart),
      .cnt       (cnt),
      .force_v   (force_v),
      .last_chan (last_chan),
      .nxt_chan  (nxt_chan),
      .nxt_cnt   (nxt_cnt),
      .nxt_force (nxt_force),
      .nxt_last  (nxt_last)
   );

   conv_seq_slot #(.CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .conv_done  (conv_done),
      .rate       (ctrl.rate),
      .mix        (ctrl.mix),
      .nxt_chan   (nxt_chan),
      .nxt_cnt    (nxt_cnt),
      .nxt_force  (nxt_force),
      .nxt_last   (nxt_last),
      .slot_chan  (slot_chan),
      .cnt        (cnt),
      .force_v    (force_v),
      .last_chan  (last_chan),
      .conv_start (conv_start),
      .restart    (restart),
      .accept     (accept),
      .drop       (drop)
   );

   conv_seq_route #(.DATA_W(DATA_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .drop      (drop),
      .chan      (slot_chan),
      .data      (conv_data),
      .hold_q    (hold_q),
      .res_valid (res_valid),
      .res_chan  (tag)
   );

   always_comb begin
      unique case (slot_chan)
         CH_OFF: conv_mux = MUX_ZERO;
         CH_CUR: conv_mux = MUX_DIFF;
         CH_AUX: conv_mux = MUX_AUXPIN;
         default: begin
            unique case (ctrl.src)
               SRC_SUPPLY: conv_mux = MUX_SUPPLY;
               SRC_AUXPIN: conv_mux = MUX_AUXPIN;
               default:    conv_mux = MUX_SENSEP;
            endcase
         end
      endcase
   end

   assign conv_chan = slot_chan;
   assign res_chan  = tag;
   assign offset_q  = hold_q[CH_OFF];
   assign current_q = hold_q[CH_CUR];
   assign volt_q    = hold_q[CH_VOLT];
   assign aux_q     = hold_q[CH_AUX];

   p_volt_mux_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && slot_chan == CH_VOLT) |->
      (conv_mux == MUX_SUPPLY || conv_mux == MUX_SENSEP || conv_mux == MUX_AUXPIN));

endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
   import conv_seq_pkg::*;

   localparam int DW = 12;
   localparam int NS = 18;

   typedef struct packed {
      logic [6:0]      ctrl;
      logic [2:0]      vmux;
      logic [8*NS-1:0] pat;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{7'h04, 3'd3, "KVKIKAKVKIKAKVKIKA"},
      '{7'h05, 3'd3, "KVIAVIAVIAVIAVIAKV"},
      '{7'h02, 3'd2, "KVIAVIAVKIAVIAVIKA"},
      '{7'h67, 3'd3, "KVIIIIIIIIIIIIIIII"},
      '{7'h18, 3'd4, "KVKIKVKIKVKIKVKIKV"},
      '{7'h0F, 3'd3, "KVIAVIAVIAVIAVIAVI"}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ctrl_we;
   logic [6:0]    ctrl_wdata;
   logic          conv_start;
   logic [2:0]    conv_mux;
   logic [1:0]    conv_chan;
   logic          conv_done;
   logic [DW-1:0] conv_data;
   logic          res_valid;
   logic [1:0]    res_chan;
   logic [DW-1:0] offset_q, current_q, volt_q, aux_q;

   always #10 clk = ~clk;

   conv_sequencer i_conv_sequencer (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .conv_start(conv_start), .conv_mux(conv_mux), .conv_chan(conv_chan),
      .conv_done(conv_done), .conv_data(conv_data), .res_valid(res_valid),
      .res_chan(res_chan), .offset_q(offset_q), .current_q(current_q),
      .volt_q(volt_q), .aux_q(aux_q)
   );

   int            checks = 0;
   int            fails  = 0;
   int            seq    = 0;
   int            lat    = 0;
   int            nlog   = 0;
   logic          busy = 1'b0, wseen = 1'b0;
   logic          pend_ok = 1'b0, pend_drop = 1'b0;
   logic [3:0]    pend_mask, cur_mask;
   logic [DW-1:0] pend_data, cur_data;
   logic [4*DW-1:0] snap;
   logic [2:0]    vmux = 3'd3;
   logic [2:0]    log_mux [32];
   logic          wr_req = 1'b0, wr_at_done = 1'b0, spur_req = 1'b0;
   logic [6:0]    wr_val = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] vmux_of(input logic [1:0] s);
      case (s)
         2'b00:   return 3'd2;
         2'b10:   return 3'd4;
         default: return 3'd3;
      endcase
   endfunction

   function automatic logic [2:0] code_of(input logic [7:0] c, input logic [2:0] vm);
      case (c)
         "K":     return 3'd1;
         "I":     return 3'd0;
         "A":     return 3'd4;
         default: return vm;
      endcase
   endfunction

   function automatic logic [DW-1:0] hold_of(input logic [1:0] t);
      case (t)
         2'd0:    return offset_q;
         2'd1:    return current_q;
         2'd2:    return volt_q;
         default: return aux_q;
      endcase
   endfunction

   task automatic tick();
      logic done_now, start_now, do_wr;
      @(negedge clk);
      if (pend_ok) begin
         chk(res_valid == 1'b1, "R9", "valid after done", res_valid, 1);
         chk(pend_mask[res_chan], "R9", "result tag", res_chan, pend_mask);
         chk(hold_of(res_chan) == pend_data, "R9", "holding register", hold_of(res_chan), pend_data);
      end else if (pend_drop) begin
         chk(res_valid == 1'b0, "R10", "valid on dropped result", res_valid, 0);
         chk({aux_q, volt_q, current_q, offset_q} == snap, "R10", "holding registers changed",
             offset_q, snap[DW-1:0]);
      end else if (res_valid) begin
         chk(1'b0, "R9", "unexpected valid", 1, 0);
      end
      pend_ok   = 1'b0;
      pend_drop = 1'b0;
      snap      = {aux_q, volt_q, current_q, offset_q};
      ctrl_we   = 1'b0;
      conv_done = 1'b0;

      done_now  = busy && (lat <= 1);
      if (busy && !done_now) lat--;
      start_now = conv_start;
      do_wr = wr_req && (wr_at_done ? done_now : ((busy && !done_now) || start_now));

      if (done_now) begin
         conv_done = 1'b1;
         conv_data = cur_data;
         busy      = 1'b0;
         if (wseen || do_wr) pend_drop = 1'b1;
         else begin
            pend_ok   = 1'b1;
            pend_mask = cur_mask;
            pend_data = cur_data;
         end
      end
      if (start_now) begin
         if (nlog < 32) log_mux[nlog] = conv_mux;
         nlog++;
         busy     = 1'b1;
         wseen    = 1'b0;
         lat      = 1 + (seq % 4);
         seq++;
         cur_data = DW'(seq * 37 + 5);
         cur_mask = {conv_mux == 3'd4, conv_mux == vmux, conv_mux == 3'd0, conv_mux == 3'd1};
         if (spur_req) begin
            conv_done = 1'b1;
            conv_data = 12'hABC;
            pend_drop = 1'b1;
            spur_req  = 1'b0;
         end
      end
      if (do_wr) begin
         ctrl_we    = 1'b1;
         ctrl_wdata = wr_val;
         wr_req     = 1'b0;
         vmux       = vmux_of(wr_val[3:2]);
         if (busy) wseen = 1'b1;
         nlog = 0;
      end
   endtask

   task automatic wait_starts(input int n);
      while (nlog < n) tick();
   endtask

   task automatic check_pattern(input vec_t v, input string req, input string first_req);
      for (int i = 0; i < NS; i++) begin
         logic [2:0] e;
         e = code_of(v.pat[8*(NS-1-i) +: 8], v.vmux);
         chk(log_mux[i] == e, (i == 0) ? first_req : ((i == 1) ? "R8" : req),
             $sformatf("slot %0d mux", i), log_mux[i], e);
      end
   endtask

   function automatic string vreq(input int i);
      case (i)
         0:       return "R3";
         1:       return "R4";
         2:       return "R5";
         3:       return "R7";
         4:       return "R7";
         default: return "R6";
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = '0; conv_done = 1'b0; conv_data = '0;
      repeat (3) tick();
      chk(conv_start == 1'b0, "R12", "start in reset", conv_start, 0);
      chk(res_valid == 1'b0, "R12", "valid in reset", res_valid, 0);
      chk({offset_q, current_q, volt_q, aux_q} == '0, "R12", "holding reset", offset_q, 0);
      rst_n = 1'b1;

      // R1 and R12: reset defaults give the every-other round robin on the positive sense input
      wait_starts(NS);
      check_pattern(VECS[0], "R12", "R1");

      // table of control words, each written while a conversion is in progress
      for (int v = 0; v < NV; v++) begin
         wr_val = VECS[v].ctrl; wr_at_done = 1'b0; wr_req = 1'b1;
         while (wr_req) tick();
         wait_starts(NS);
         check_pattern(VECS[v], vreq(v), "R2");
      end

      // R2 / R10: write in the same cycle as the done strobe
      wr_val = 7'h04; wr_at_done = 1'b1; wr_req = 1'b1;
      while (wr_req) tick();
      wait_starts(2);
      chk(log_mux[0] == 3'd1, "R2", "calibration after write at done", log_mux[0], 1);
      chk(log_mux[1] == 3'd3, "R2", "voltage after write at done", log_mux[1], 3);

      // R11: done strobe in a start cycle is ignored
      spur_req = 1'b1;
      while (spur_req) tick();
      nlog = 0;
      wait_starts(4);
      chk(log_mux[0] != log_mux[1], "R11", "schedule advanced once per slot", log_mux[1], log_mux[0]);
      repeat (4) tick();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule